// File: doc/BRIEF.md
# Push-Button Accelerating Up/Down Counter

This block turns two active-low push-button levels into a saturating wiper position that drives the code input of a DAC. One button raises the position and the other lowers it. Both inputs are first synchronised to the system clock. They are then qualified on a millisecond timebase that is divided down from that clock, so contact bounce and short glitches never reach the counter.

A press that lasts through the qualification window gives a single step. If the button is held, the step repeats at a slow rate for the first second and then at a fast rate until the button is released. The position stops at both ends of its range and never wraps. A one-cycle load port presets the position from a recalled value. An inhibit input from store control suspends all button activity while a store is pending. A one-cycle strobe marks every button-driven change of the position.

Top module: `pb_step_counter`

## Requirements
- R1: `up_n` low raises `pos` by one and `dn_n` low lowers it by one; each qualified press gives its first step after the qualification window.
- R2: A low level shorter than DEBOUNCE_MS (30 ms) leaves `pos` unchanged; a low level held for 30 ms gives exactly one step.
- R3: While one button stays held, further steps follow every SLOW_MS (250 ms) during the first ACCEL_MS (1000 ms) after the first step, so a 200 ms hold gives one step and a 300 ms hold gives two.
- R4: Once ACCEL_MS has passed since the first step, repeat steps follow every FAST_MS (50 ms) until release (1100 ms hold: 6 steps; 1300 ms hold: 10 steps).
- R5: Releasing the button returns the block to idle, and the next press starts again with a full qualification window and the slow phase.
- R6: `pos` saturates at 0xFF going up and at 0x00 going down, with no wrap, and `step` stays low when a saturated step is refused.
- R7: While `store_inhibit` is high, presses are ignored. A press that is in progress, or that is seen while inhibited, produces no further step until both buttons have been released.
- R8: When both buttons are low, neither steps, and the block stays blocked until both are released. Releasing only one of them does not resume stepping.
- R9: `load_en` high for a cycle sets `pos` to `load_val` on the next edge, and it overrides any step requested in the same cycle. That cycle gives no `step`.
- R10: `step` is high for exactly one cycle in the same cycle as each button-driven change of `pos`, so the pulse count equals the number of steps taken.
- R11: After reset `pos` is 0x00 and `step` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| up_n | input | 1 | Raise button, active low, asynchronous |
| dn_n | input | 1 | Lower button, active low, asynchronous |
| store_inhibit | input | 1 | High while store control blocks button activity |
| load_en | input | 1 | One-cycle preset strobe |
| load_val | input | POS_W | Value written to the position on `load_en` |
| pos | output | POS_W | Current wiper position (DAC code) |
| step | output | 1 | One-cycle strobe on each button-driven position change |

## Verification
Several rules are checked by assertions on every cycle:
- the position never jumps by anything other than one step except on a load, and never wraps;
- a load always lands on the following edge without a strobe;
- the controller never requests a step while inhibited, while both buttons are low, or in the cycle after leaving idle;
- a step is only requested in the direction of the button that is actually held.

The timing rules can only be shown by the bench's scenarios, because they span many milliseconds. These are the 30 ms rejection window, the 250 ms and 50 ms repeat intervals, the switch to the fast rate after one second, and the restart after release. The bench shows each of them as a step count after a hold of chosen length, with every hold length placed well away from a step boundary.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    // Repeat controller phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEBOUNCE,
        ST_SLOW,
        ST_FAST,
        ST_BLOCK
    } rpt_state_e;

    // Decoded pair of synchronised button levels
    typedef enum logic [1:0] {
        BTN_NONE,
        BTN_UP,
        BTN_DN,
        BTN_BOTH
    } btn_code_e;

    // Step request from controller to position register
    typedef struct packed {
        logic inc;
        logic dec;
    } step_req_t;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Inputs are active-low levels
    function automatic btn_code_e decode_buttons(input logic up_lvl_n, input logic dn_lvl_n);
        case ({up_lvl_n, dn_lvl_n})
            2'b01:   return BTN_UP;
            2'b10:   return BTN_DN;
            2'b00:   return BTN_BOTH;
            default: return BTN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pbc_ms_tick.sv
module pbc_ms_tick #(
    parameter int unsigned CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned DIV = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
    localparam int unsigned CW  = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = (cnt_q == LAST);

    generate
        if (DIV > 1) begin : g_tick_chk
            // Millisecond tick never fires on two adjacent cycles (timebase for R3/R4)
            p_tick_spacing_r3: assert property (@(posedge clk) disable iff (rst)
                tick_o |=> !tick_o)
                else $error("tick fired on consecutive cycles");
        end
    endgenerate

endmodule

// File: rtl/pbc_input_sync.sv
module pbc_input_sync #(
    parameter int unsigned N      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    generate
        for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= '1;   // released level
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], din[b]};
                end
            end
            assign dout[b] = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pbc_repeat_ctrl.sv
module pbc_repeat_ctrl
    import pbc_pkg::*;
#(
    parameter int unsigned DEBOUNCE_MS = 30,
    parameter int unsigned SLOW_MS     = 250,
    parameter int unsigned FAST_MS     = 50,
    parameter int unsigned ACCEL_MS    = 1000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      up_lvl_n,
    input  logic      dn_lvl_n,
    input  logic      inhibit,
    output step_req_t req_o
);
    localparam int unsigned IVL_MAX = max_of(DEBOUNCE_MS, max_of(SLOW_MS, FAST_MS));
    localparam int unsigned IW      = $clog2(IVL_MAX + 1);
    localparam int unsigned HW      = $clog2(ACCEL_MS + 1);
    localparam logic [IW-1:0] DEB_LAST  = IW'(DEBOUNCE_MS - 1);
    localparam logic [IW-1:0] SLOW_LAST = IW'(SLOW_MS - 1);
    localparam logic [IW-1:0] FAST_LAST = IW'(FAST_MS - 1);
    localparam logic [HW-1:0] ACC_LAST  = HW'(ACCEL_MS - 1);

    rpt_state_e    state_q, state_d;
    logic [IW-1:0] ivl_q, ivl_d;
    logic [HW-1:0] hold_q, hold_d;
    logic          dir_up_q, dir_up_d;
    btn_code_e     btn;
    logic          held_ok;
    logic          fire;

    always_comb begin
        state_d  = state_q;
        ivl_d    = ivl_q;
        hold_d   = hold_q;
        dir_up_d = dir_up_q;
        fire     = 1'b0;
        btn      = decode_buttons(up_lvl_n, dn_lvl_n);
        held_ok  = dir_up_q ? (btn == BTN_UP) : (btn == BTN_DN);

        case (state_q)
            ST_IDLE: begin
                ivl_d  = '0;
                hold_d = '0;
                if (btn != BTN_NONE) begin
                    if (inhibit || btn == BTN_BOTH) begin
                        state_d = ST_BLOCK;
                    end else begin
                        state_d  = ST_DEBOUNCE;
                        dir_up_d = (btn == BTN_UP);
                    end
                end
            end
            ST_BLOCK: begin
                if (btn == BTN_NONE) state_d = ST_IDLE;
            end
            default: begin
                if (inhibit || btn == BTN_BOTH) begin
                    state_d = ST_BLOCK;
                end else if (!held_ok) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    case (state_q)
                        ST_DEBOUNCE: begin
                            if (ivl_q == DEB_LAST) begin
                                fire    = 1'b1;
                                ivl_d   = '0;
                                hold_d  = '0;
                                state_d = ST_SLOW;
                            end else begin
                                ivl_d = ivl_q + 1'b1;
                            end
                        end
                        ST_SLOW: begin
                            hold_d = hold_q + 1'b1;
                            if (ivl_q == SLOW_LAST) begin
                                fire  = 1'b1;
                                ivl_d = '0;
                            end else begin
                                ivl_d = ivl_q + 1'b1;
                            end
                            if (hold_q == ACC_LAST) begin
                                state_d = ST_FAST;
                                ivl_d   = '0;
                            end
                        end
                        ST_FAST: begin
                            if (ivl_q == FAST_LAST) begin
                                fire  = 1'b1;
                                ivl_d = '0;
                            end else begin
                                ivl_d = ivl_q + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        endcase

        req_o.inc = fire & dir_up_q;
        req_o.dec = fire & ~dir_up_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ivl_q    <= '0;
            hold_q   <= '0;
            dir_up_q <= 1'b1;
        end else begin
            state_q  <= state_d;
            ivl_q    <= ivl_d;
            hold_q   <= hold_d;
            dir_up_q <= dir_up_d;
        end
    end

    // R7: no step request while store control inhibits
    p_no_step_inhibit_r7: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> (req_o == '0))
        else $error("step requested while inhibited");

    // R8: both buttons low never steps
    p_both_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (!up_lvl_n && !dn_lvl_n) |-> (req_o == '0))
        else $error("step requested with both buttons held");

    // R8: never both directions at once
    p_one_dir_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_o.inc, req_o.dec}))
        else $error("both step directions requested");

    // R1: a step follows the direction of the button actually held
    p_dir_match_r1: assert property (@(posedge clk) disable iff (rst)
        (req_o.inc |-> !up_lvl_n) and (req_o.dec |-> !dn_lvl_n))
        else $error("step direction does not match held button");

    // R2: no step can come right after idle (qualification window first)
    p_qualify_first_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> (req_o == '0))
        else $error("step without qualification window");

endmodule

// File: rtl/pbc_position.sv
module pbc_position
    import pbc_pkg::*;
#(
    parameter int unsigned POS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  step_req_t        req,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] pos_o,
    output logic             step_o
);
    localparam logic [POS_W-1:0] TOP = '1;
    localparam logic [POS_W-1:0] BOT = '0;

    logic [POS_W-1:0] pos_q, pos_d;
    logic             step_q, step_d;

    always_comb begin
        pos_d  = pos_q;
        step_d = 1'b0;
        if (load_en) begin
            pos_d = load_val;
        end else if (req.inc && pos_q != TOP) begin
            pos_d  = pos_q + 1'b1;
            step_d = 1'b1;
        end else if (req.dec && pos_q != BOT) begin
            pos_d  = pos_q - 1'b1;
            step_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            step_q <= 1'b0;
        end else begin
            pos_q  <= pos_d;
            step_q <= step_d;
        end
    end

    assign pos_o  = pos_q;
    assign step_o = step_q;

    // R9: load lands next edge, without a strobe
    p_load_wins_r9: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (pos_q == $past(load_val)) && !step_q)
        else $error("load did not take effect");

    // R6: any non-load change is a single unit move, never a wrap
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_en) && (pos_q != $past(pos_q))) |->
        (({1'b0, pos_q} == {1'b0, $past(pos_q)} + 1'b1) ||
         ({1'b0, $past(pos_q)} == {1'b0, pos_q} + 1'b1)))
        else $error("position moved by more than one or wrapped");

    // R10: strobe only accompanies a real change
    p_step_moves_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && step_q) |-> (pos_q != $past(pos_q)))
        else $error("strobe without position change");

endmodule

// File: rtl/pb_step_counter.sv
module pb_step_counter
    import pbc_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 100_000_000,
    parameter int unsigned POS_W       = 8,
    parameter int unsigned DEBOUNCE_MS = 30,
    parameter int unsigned SLOW_MS     = 250,
    parameter int unsigned FAST_MS     = 50,
    parameter int unsigned ACCEL_MS    = 1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             up_n,
    input  logic             dn_n,
    input  logic             store_inhibit,
    input  logic             load_en,
    input  logic [POS_W-1:0] load_val,
    output logic [POS_W-1:0] pos,
    output logic             step
);
    logic      tick;
    logic [1:0] btn_sync;
    step_req_t req;

    pbc_ms_tick #(.CLK_HZ(CLK_HZ)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    pbc_input_sync #(.N(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({up_n, dn_n}),
        .dout (btn_sync)
    );

    pbc_repeat_ctrl #(
        .DEBOUNCE_MS (DEBOUNCE_MS),
        .SLOW_MS     (SLOW_MS),
        .FAST_MS     (FAST_MS),
        .ACCEL_MS    (ACCEL_MS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .up_lvl_n (btn_sync[1]),
        .dn_lvl_n (btn_sync[0]),
        .inhibit  (store_inhibit),
        .req_o    (req)
    );

    pbc_position #(.POS_W(POS_W)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .load_en  (load_en),
        .load_val (load_val),
        .pos_o    (pos),
        .step_o   (step)
    );

endmodule

// File: tb/pb_step_counter_tb_top.sv
module pb_step_counter_tb_top;

    localparam int CPM = 10;   // clock cycles per millisecond in this bench

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_n = 1'b1;
    logic       dn_n = 1'b1;
    logic       store_inhibit = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic [7:0] pos;
    logic       step;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    bit done = 0;

    always #5 clk = ~clk;   // 100 MHz

    pb_step_counter #(.CLK_HZ(CPM * 1000)) dut_i (
        .clk(clk), .rst(rst), .up_n(up_n), .dn_n(dn_n),
        .store_inhibit(store_inhibit), .load_en(load_en), .load_val(load_val),
        .pos(pos), .step(step)
    );

    always @(negedge clk) if (!rst && step) n_pulse++;

    typedef struct packed {
        logic [1:0]  btn;    // 0 none, 1 up, 2 down, 3 both
        logic [15:0] ms;
        logic        inh;
        int          delta;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 16'd10,   1'b0,   0},   // R2 short glitch
        '{2'd1, 16'd40,   1'b0,   1},   // R1 single step up
        '{2'd1, 16'd200,  1'b0,   1},   // R3 no repeat yet
        '{2'd1, 16'd300,  1'b0,   2},   // R3 one slow repeat
        '{2'd2, 16'd600,  1'b0,  -3},   // R3 slow repeats down
        '{2'd1, 16'd1100, 1'b0,   6},   // R4 into fast rate
        '{2'd2, 16'd1300, 1'b0, -10},   // R4 fast rate down
        '{2'd3, 16'd500,  1'b0,   0},   // R8 both held
        '{2'd1, 16'd400,  1'b1,   0},   // R7 inhibited
        '{2'd2, 16'd20,   1'b0,   0}    // R2 short glitch down
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 9:    return "R2";
            1:       return "R1";
            2, 3, 4: return "R3";
            5, 6:    return "R4";
            7:       return "R8";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ms(input int ms);
        repeat (ms * CPM) @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        @(negedge clk);
        load_en = 1'b1;
        load_val = v;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic drive_btn(input logic [1:0] b);
        up_n = ~b[0];
        dn_n = ~b[1];
    endtask

    task automatic press(input logic [1:0] b, input int ms);
        @(negedge clk);
        drive_btn(b);
        wait_ms(ms);
        drive_btn(2'b00);
        wait_ms(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset pos", int'(pos), 0);
        check("R11 reset step", int'(step), 0);

        // Table walk: each vector starts from mid-scale
        for (int i = 0; i < NV; i++) begin
            do_load(8'h80);
            n_pulse = 0;
            store_inhibit = VECS[i].inh;
            press(VECS[i].btn, int'(VECS[i].ms));
            store_inhibit = 1'b0;
            check(vec_req(i), int'(pos), 128 + VECS[i].delta);
            check("R10 pulse count", n_pulse,
                  (VECS[i].delta < 0) ? -VECS[i].delta : VECS[i].delta);
        end

        // R6 saturation at the top, no strobes once stuck
        do_load(8'hFE);
        n_pulse = 0;
        press(2'b01, 600);
        check("R6 top saturate", int'(pos), 255);
        check("R6 top strobes", n_pulse, 1);

        // R6 saturation at the bottom
        do_load(8'h01);
        n_pulse = 0;
        press(2'b10, 600);
        check("R6 bottom saturate", int'(pos), 0);
        check("R6 bottom strobes", n_pulse, 1);

        // R9 load held across a repeating press overrides every step
        @(negedge clk);
        load_val = 8'h33;
        load_en = 1'b1;
        n_pulse = 0;
        press(2'b01, 400);
        load_en = 1'b0;
        @(negedge clk);
        check("R9 load override pos", int'(pos), 8'h33);
        check("R9 load override strobes", n_pulse, 0);

        // R5 release then quick re-press: each press qualifies anew
        do_load(8'h40);
        @(negedge clk);
        drive_btn(2'b01);
        wait_ms(40);
        drive_btn(2'b00);
        wait_ms(20);
        drive_btn(2'b01);
        wait_ms(40);
        drive_btn(2'b00);
        wait_ms(5);
        check("R5 two separate presses", int'(pos), 8'h42);

        // R5 re-press after a long hold starts slow again
        do_load(8'h40);
        press(2'b01, 1100);
        press(2'b01, 200);
        check("R5 restart in slow phase", int'(pos), 8'h40 + 6 + 1);

        // R7 inhibit mid-press, then dropped while still held
        do_load(8'h80);
        @(negedge clk);
        drive_btn(2'b01);
        wait_ms(100);
        store_inhibit = 1'b1;
        wait_ms(400);
        store_inhibit = 1'b0;
        wait_ms(400);
        drive_btn(2'b00);
        wait_ms(5);
        check("R7 held through inhibit", int'(pos), 8'h81);

        // R8 both held then only one released: still blocked
        do_load(8'h80);
        @(negedge clk);
        drive_btn(2'b11);
        wait_ms(100);
        drive_btn(2'b01);
        wait_ms(300);
        drive_btn(2'b00);
        wait_ms(5);
        check("R8 partial release stays blocked", int'(pos), 8'h80);

        // R11 reset mid-scale returns to zero
        do_load(8'h77);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset clears pos", int'(pos), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule